// File: doc/BRIEF.md
# Partitioned SIMD Signed Rounding Averager

This block averages two 128-bit vectors lane by lane. A size code picked on each request splits both operands into lanes of 8, 16, 32 or 64 bits. Every lane pair is read as two signed two's-complement integers. The lane result is their average with a rounding increment, and the result vector uses the same lane layout as the operands. All lane widths share one datapath, and no carry passes from one lane into the next.

A request is one cycle with the valid input high. One cycle later the block answers in one of two ways. If the size code is supported, it pulses the result-valid output and presents the new result. If the size code is not supported, it pulses the exception output and leaves the result register as it was. Requests may arrive back to back, one per clock.

Top module: `savg_simd_avg`

## Requirements
- R1: Size code 0 selects 8-bit lanes (16 lanes), 1 selects 16-bit lanes (8 lanes), 2 selects 32-bit lanes (4 lanes) and 3 selects 64-bit lanes (2 lanes). The size code port is 4 bits wide.
- R2: Each lane result equals floor((a + b + 1) / 2), where a and b are the signed two's-complement values of that lane in the two operands.
- R3: No overflow is lost, so each lane result lies between its two operands. The most negative value averaged with itself returns that value, the most positive value averaged with itself returns that value, and -1 averaged with 0 gives 0.
- R4: Carries never cross a lane boundary of the selected width.
- R5: Lane 0 occupies the most significant bits of the operands (bits 127 down to 128-W), and the result uses the same layout.
- R6: A legal request is answered exactly one cycle later, with result-valid high and the new result on the output.
- R7: A request whose size code is 4 or greater raises the exception output one cycle later, leaves result-valid low, and leaves the result output unchanged.
- R8: Each request produces exactly one of result-valid and exception. Neither output is high in a cycle that follows a cycle without a request.
- R9: While reset is asserted, result-valid, exception and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Request strobe |
| opa_i | input | 128 | First operand vector |
| opb_i | input | 128 | Second operand vector |
| size_i | input | 4 | Element-size code |
| avg_o | output | 128 | Registered lane-wise average |
| avg_vld_o | output | 1 | Result-valid pulse, one cycle after a legal request |
| spec_exc_o | output | 1 | Exception pulse, one cycle after an illegal request |

## Verification
Once a request has been made, the block holds no state apart from the result register and the two strobes. A fault in the lane arithmetic, in the lane slicing or in the width select therefore shows in avg_o on the cycle right after the request. A lane swap makes lane 0 read back wrong, and a carry that crosses a boundary corrupts the neighbouring lane. A fault in the strobe logic or in the hold of the result register shows on the same cycle, as a missing or doubled strobe or as a result that changes after an illegal request. A behavioural model is compared against the outputs on every cycle, so the first wrong cycle is reported.

// File: rtl/savg_pkg.sv
package savg_pkg;
  // Vector width and the set of lane widths it can be split into
  localparam int VEC_W     = 128;
  localparam int SZ_W      = 4;
  localparam int NUM_SIZES = 4;
  localparam int BASE_W    = 8;
  localparam int SEL_W     = $clog2(NUM_SIZES);

  // Lane width chosen by a given size code
  function automatic int lane_width(input int code);
    return BASE_W << code;
  endfunction
endpackage

// File: rtl/savg_lane.sv
// One signed rounding-average lane of width W.
// (a + b + 1) >> 1 is computed as (a>>>1) + (b>>>1) + (a[0] | b[0]).
// The partial sums fit in W bits, so no extra bit has to be carried.
module savg_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] avg_o
);
  logic [W-1:0] a_half;
  logic [W-1:0] b_half;
  logic [W-1:0] rnd;

  always_comb begin
    a_half = {a_i[W-1], a_i[W-1:1]};
    b_half = {b_i[W-1], b_i[W-1:1]};
    rnd    = W'(a_i[0] | b_i[0]);
    avg_o  = a_half + b_half + rnd;
  end

  // R3: the average never leaves the interval spanned by its operands
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      if ($signed(a_i) <= $signed(b_i)) begin
        assert_in_range_R3: assert (($signed(avg_o) >= $signed(a_i)) &&
                                    ($signed(avg_o) <= $signed(b_i)));
      end else begin
        assert_in_range_swap_R3: assert (($signed(avg_o) >= $signed(b_i)) &&
                                         ($signed(avg_o) <= $signed(a_i)));
      end
    end
  end
endmodule

// File: rtl/savg_width_bank.sv
// All lanes for one fixed lane width. Lane 0 sits at the MSB end (R5).
// Every lane is a separate adder, so no carry crosses a boundary (R4).
module savg_width_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] avg_o
);
  localparam int N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam int HI = VEC_W - 1 - i * LANE_W;
    savg_lane #(.W(LANE_W)) u_lane (
      .a_i  (a_i[HI -: LANE_W]),
      .b_i  (b_i[HI -: LANE_W]),
      .avg_o(avg_o[HI -: LANE_W])
    );
  end
endmodule

// File: rtl/savg_out_stage.sv
// Response registers: the result (loaded only on a legal request) and the
// two mutually exclusive strobes.
module savg_out_stage #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             legal_i,
  input  logic [VEC_W-1:0] avg_i,
  output logic [VEC_W-1:0] avg_o,
  output logic             vld_o,
  output logic             exc_o
);
  logic             vld_d, exc_d, ld_en;
  logic             vld_q, exc_q;
  logic [VEC_W-1:0] avg_q;

  always_comb begin
    vld_d = req_i & legal_i;
    exc_d = req_i & ~legal_i;
    ld_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      exc_q <= exc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q <= '0;
    end else if (ld_en) begin
      avg_q <= avg_i;
    end
  end

  assign avg_o = avg_q;
  assign vld_o = vld_q;
  assign exc_o = exc_q;

  // R6: a legal request raises result-valid on the next cycle
  assert_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && legal_i) |=> vld_o);

  // R7: an illegal request raises the exception and keeps the old result
  assert_hold_on_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !legal_i) |=> (exc_o && !vld_o && $stable(avg_o)));

  // R8: never both strobes at once
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vld_o, exc_o}));

  // R8: no strobe without a request on the cycle before
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!vld_o && !exc_o));
endmodule

// File: rtl/savg_simd_avg.sv
module savg_simd_avg #(
  parameter int VEC_W     = savg_pkg::VEC_W,
  parameter int SZ_W      = savg_pkg::SZ_W,
  parameter int NUM_SIZES = savg_pkg::NUM_SIZES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic [VEC_W-1:0] avg_o,
  output logic             avg_vld_o,
  output logic             spec_exc_o
);
  localparam int SEL_W = $clog2(NUM_SIZES);

  logic             size_legal;
  logic [SEL_W-1:0] size_sel;
  logic [VEC_W-1:0] bank_avg [NUM_SIZES];
  logic [VEC_W-1:0] sel_avg;

  // Size decode (R1, R7)
  always_comb begin
    size_legal = (size_i < SZ_W'(NUM_SIZES));
    size_sel   = size_i[SEL_W-1:0];
  end

  // One lane bank per supported width, all sharing the operands
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
    savg_width_bank #(
      .VEC_W (VEC_W),
      .LANE_W(savg_pkg::lane_width(k))
    ) u_bank (
      .a_i  (opa_i),
      .b_i  (opb_i),
      .avg_o(bank_avg[k])
    );
  end

  always_comb sel_avg = bank_avg[size_sel];

  savg_out_stage #(.VEC_W(VEC_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (in_vld_i),
    .legal_i(size_legal),
    .avg_i  (sel_avg),
    .avg_o  (avg_o),
    .vld_o  (avg_vld_o),
    .exc_o  (spec_exc_o)
  );
endmodule

// File: tb/savg_simd_avg_tb.sv
`timescale 1ns/1ps
module savg_simd_avg_tb;
  logic         clk;
  logic         rst_n;
  logic         in_vld;
  logic [127:0] opa, opb;
  logic [3:0]   size;
  logic [127:0] avg;
  logic         avg_vld, spec_exc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  savg_simd_avg u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld_i  (in_vld),
    .opa_i     (opa),
    .opb_i     (opb),
    .size_i    (size),
    .avg_o     (avg),
    .avg_vld_o (avg_vld),
    .spec_exc_o(spec_exc)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Behavioural reference: lane 0 at the MSB end, signed floor((a+b+1)/2)
  function automatic logic [127:0] ref_avg(input logic [127:0] a,
                                           input logic [127:0] b,
                                           input int w);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 128 / w; i++) begin
      int lo;
      logic signed [65:0] ea, eb, s;
      lo = 128 - (i + 1) * w;
      for (int k = 0; k < 66; k++) begin
        ea[k] = a[lo + ((k < w) ? k : w - 1)];
        eb[k] = b[lo + ((k < w) ? k : w - 1)];
      end
      s = (ea + eb + 66'sd1) >>> 1;
      for (int k = 0; k < w; k++) r[lo + k] = s[k];
    end
    return r;
  endfunction

  // Cycle model of the registered outputs
  logic         m_vld, m_exc;
  logic [127:0] m_res;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld <= 0; m_exc <= 0; m_res <= '0;
    end else begin
      m_vld <= in_vld && (size < 4);
      m_exc <= in_vld && (size >= 4);
      if (in_vld && size < 4) m_res <= ref_avg(opa, opb, 8 << size);
    end
  end

  task automatic check(input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 result-valid", {127'd0, avg_vld}, {127'd0, m_vld});
      check("R7 exception", {127'd0, spec_exc}, {127'd0, m_exc});
      check("R8 one strobe", {127'd0, avg_vld & spec_exc}, 128'd0);
      check("R2 result", avg, m_res);
    end
  end

  // Directed request: drive on a falling edge, check the answer one cycle later
  task automatic req(input logic [127:0] a, input logic [127:0] b,
                     input logic [3:0] sz, input logic [127:0] exp,
                     input string tag);
    @(negedge clk);
    in_vld = 1; opa = a; opb = b; size = sz;
    @(negedge clk);
    in_vld = 0;
    check(tag, avg, exp);
  endtask

  initial begin
    logic [127:0] prev;
    rst_n = 0; in_vld = 0; opa = '0; opb = '0; size = '0;
    #23;
    check("R9 reset result", avg, 128'd0);
    check("R9 reset strobes", {126'd0, avg_vld, spec_exc}, 128'd0);
    @(negedge clk); rst_n = 1;

    // R1 width select: same operands, four sizes
    req({16{8'h03}}, {16{8'h04}}, 4'd0, {16{8'h04}}, "R1 size0");
    req({8{16'h00ff}}, {8{16'h0100}}, 4'd1, {8{16'h0100}}, "R1 size1");
    req({4{32'h0000ffff}}, {4{32'h00010000}}, 4'd2, {4{32'h00010000}}, "R1 size2");
    req({2{64'h00000000ffffffff}}, {2{64'h0000000100000000}}, 4'd3,
        {2{64'h0000000100000000}}, "R1 size3");
    // R2 rounding on negative odd sums: -3 and 0 give -1
    req({16{8'hfd}}, 128'd0, 4'd0, {16{8'hff}}, "R2 neg round");
    // R3 corners for each width
    req({16{8'h80}}, {16{8'h80}}, 4'd0, {16{8'h80}}, "R3 min8");
    req({16{8'h7f}}, {16{8'h7f}}, 4'd0, {16{8'h7f}}, "R3 max8");
    req({128{1'b1}}, 128'd0, 4'd0, 128'd0, "R3 minus1 zero");
    req({2{64'h8000000000000000}}, {2{64'h8000000000000000}}, 4'd3,
        {2{64'h8000000000000000}}, "R3 min64");
    req({2{64'h7fffffffffffffff}}, {2{64'h7fffffffffffffff}}, 4'd3,
        {2{64'h7fffffffffffffff}}, "R3 max64");
    req({4{32'h7fffffff}}, {4{32'h80000000}}, 4'd2, 128'd0, "R3 max min32");
    // R4 carry isolation
    req({128{1'b1}}, {16{8'h01}}, 4'd0, 128'd0, "R4 no carry8");
    req({8{16'h7fff}}, {8{16'h0001}}, 4'd1, {8{16'h4000}}, "R4 no carry16");
    // R5 lane 0 at the MSB end
    req({16'h0002, 112'd0}, 128'd0, 4'd1, {16'h0001, 112'd0}, "R5 lane0 msb");
    req({64'd0, 64'd6}, 128'd0, 4'd3, {64'd0, 64'd3}, "R5 last lane lsb");
    // R7 illegal codes keep the result and raise the exception
    prev = avg;
    @(negedge clk); in_vld = 1; opa = '1; opb = '1; size = 4'd4;
    @(negedge clk); in_vld = 0;
    check("R7 exc raised", {127'd0, spec_exc}, 128'd1);
    check("R7 result held", avg, prev);
    req('1, '1, 4'd15, prev, "R7 code15 held");
    // R6 back-to-back requests, random operands and sizes
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      in_vld = ($urandom_range(0, 3) != 0);
      opa = {$urandom, $urandom, $urandom, $urandom};
      opb = {$urandom, $urandom, $urandom, $urandom};
      size = 4'($urandom_range(0, 5));
      if (n % 7 == 0) size = 4'($urandom_range(0, 15));
    end
    @(negedge clk); in_vld = 0;
    @(negedge clk);
    // R8 idle: no strobes without requests
    check("R8 idle", {126'd0, avg_vld, spec_exc}, 128'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule